// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Nine-Bit Lane Masks

This block is a single-clock synchronous memory with a 36-bit word, split into four 9-bit lanes that can be written separately. On each rising clock edge it samples a chip select, a global write enable, one active-low enable per lane and an address. A write uses late-write timing. The edge that samples the write command only records the address and the lane mask in a pending-write register. The data word is taken on the following edge and committed to the array on that same edge. A read loads a registered output on the edge that samples it. When a read targets the address whose data is being committed on that edge, the read returns the new lanes merged with the stored ones.

The block does not drive a pad itself. It presents the read word on `rd_data` and asserts `rd_drive` when a pad ring should turn on its drivers. Drive is granted only after a read cycle, and only while the output enable is low and sleep is low. Both of these inputs act on `rd_drive` without waiting for a clock. Sleep also makes the block ignore every synchronous input. The depth is set by `ADDR_W`. The data path has no flow control: a command is taken on every clock edge, and no back-pressure is possible.

Top module: `lw_sram`

## Requirements
- R1: A word is 36 bits and holds four 9-bit lanes. Lane i is bits [9i+8:9i]. Bit i of `lane_we_n` enables lane i when it is 0.
- R2: While `sleep` is 1 at a rising edge, that edge ignores `cs_n`, `we_n`, `lane_we_n`, `addr` and `wr_data`. No command is accepted and nothing is written.
- R3: An edge with `sleep`=0 and `cs_n`=1 is a deselect. It accesses no memory, and `rd_drive` is 0 after that edge.
- R4: An edge with `sleep`=0, `cs_n`=0 and `we_n`=1 is a read. `rd_data` shows the word at `addr` from that edge on. `rd_data` keeps its value across every edge that is not a read.
- R5: `rd_drive` is 1 only if the last edge was a read and both `oe_n` and `sleep` are currently 0. A change of `oe_n` reaches `rd_drive` without a clock edge. A read taken with `oe_n`=1 still loads `rd_data`; this is a dummy read.
- R6: An edge with `sleep`=0, `cs_n`=0 and `we_n`=0 is a write command. The next edge takes `wr_data` and updates only the lanes whose enable bit was 0. The other lanes keep their contents. `wr_data` has no effect on an edge that does not follow a write command.
- R7: `rd_drive` is 0 after a write-command edge.
- R8: A read on the edge that commits a pending write to the same address returns `wr_data` in the lanes being written and the stored contents in the other lanes.
- R9: If `sleep` is 1 at the data edge of a pending write, the write is dropped. A rise of `sleep` forces `rd_drive` to 0 at once.
- R10: After reset, `rd_drive` is 0, `rd_data` is 0 and no write is pending.
- R11: Write commands on consecutive edges each commit their own data on the edge that follows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Power-down request; drive is forced off at once and commands are ignored |
| oe_n | input | 1 | Output enable, active low, combinational |
| cs_n | input | 1 | Chip select, active low, sampled |
| we_n | input | 1 | Global write enable, active low, sampled |
| lane_we_n | input | 4 | Per-lane write enables, active low, sampled |
| addr | input | ADDR_W | Word address, sampled |
| wr_data | input | 36 | Write data, taken one edge after its write command |
| rd_data | output | 36 | Registered read word |
| rd_drive | output | 1 | Bus drive request for the pad ring |

## Verification
The hardest case to reach from the ports is an edge that both commits a partially masked write and reads the same address. At that edge the array still holds the old word, so the result depends on the bypass merge. The stimulus follows every write command at once with a read of the same address. It repeats this for all sixteen lane masks on every address, using data that differs from the stored word in every lane. A second hard case is a sleep pulse that lands exactly on a data edge. It is produced by raising `sleep` between a write command and its data, and then reading the address back.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } lw_op_e;
endpackage

// File: rtl/lw_cmd_decode.sv
module lw_cmd_decode
  import lw_sram_pkg::*;
(
  input  logic   sleep,
  input  logic   cs_n,
  input  logic   we_n,
  output lw_op_e op
);
  // Sleep outranks select, and select outranks the write enable.
  always_comb begin
    if (sleep || cs_n) op = OP_NONE;
    else if (we_n)     op = OP_READ;
    else               op = OP_WRITE;
  end
endmodule

// File: rtl/lw_stage.sv
module lw_stage
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lw_op_e            op,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we_n,
  output logic              commit,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [LANES-1:0]  pend_mask,
  output logic              rd_hit
);
  logic pend_v;

  // A write command waits here for its data, which comes on the next edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_mask <= '0;
    end else begin
      pend_v <= (op == OP_WRITE);
      if (op == OP_WRITE) begin
        pend_addr <= addr;
        pend_mask <= ~lane_we_n;
      end
    end
  end

  // A data edge that falls in sleep drops the pending write (R9).
  assign commit = pend_v & ~sleep;
  assign rd_hit = commit && (op == OP_READ) && (pend_addr == addr);

  a_r6_pend_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) |=> pend_v);
  a_r2_sleep_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !pend_v);
endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    commit,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  // Each lane has its own bank, so a partial write touches only its own storage.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (commit && lane_en[l])
        bank[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
    end
    assign rd_word[l*LANE_W +: LANE_W] = bank[rd_addr];
  end
endmodule

// File: rtl/lw_out_ctl.sv
module lw_out_ctl
  import lw_sram_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lw_op_e            op,
  input  logic [WORD_W-1:0] word,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_drive
);
  logic drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      drv_q   <= 1'b0;
    end else begin
      drv_q <= (op == OP_READ);
      if (op == OP_READ) rd_data <= word;
    end
  end

  // oe_n and sleep act on the drive request without a clock (R5, R9).
  assign rd_drive = drv_q & ~oe_n & ~sleep;

  a_r4_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_READ) |=> $stable(rd_data));
  a_r7_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) |=> !rd_drive);
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    oe_n,
  input  logic                    cs_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_drive
);
  localparam int WORD_W = LANES * LANE_W;

  lw_op_e              op;
  logic                commit, rd_hit;
  logic [ADDR_W-1:0]   pend_addr;
  logic [LANES-1:0]    pend_mask;
  logic [WORD_W-1:0]   arr_word, merged;

  lw_cmd_decode u_dec (.sleep(sleep), .cs_n(cs_n), .we_n(we_n), .op(op));

  lw_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_stage (
    .clk(clk), .rst_n(rst_n), .op(op), .sleep(sleep), .addr(addr),
    .lane_we_n(lane_we_n), .commit(commit), .pend_addr(pend_addr),
    .pend_mask(pend_mask), .rd_hit(rd_hit));

  lw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .commit(commit), .wr_addr(pend_addr), .lane_en(pend_mask),
    .wr_data(wr_data), .rd_addr(addr), .rd_word(arr_word));

  // Read-after-write bypass: each lane being committed on this edge comes from wr_data (R8).
  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*LANE_W +: LANE_W] = (rd_hit && pend_mask[l])
        ? wr_data[l*LANE_W +: LANE_W] : arr_word[l*LANE_W +: LANE_W];
  end

  lw_out_ctl #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .op(op), .word(merged), .oe_n(oe_n),
    .sleep(sleep), .rd_data(rd_data), .rd_drive(rd_drive));

  a_r3_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && cs_n) |=> !rd_drive);
endmodule

// File: tb/tb_lw_sram.sv
module tb_lw_sram;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep = 1'b0, oe_n = 1'b0, cs_n = 1'b1, we_n = 1'b1;
  logic [3:0] lane_we_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data;
  logic rd_drive;

  int n_chk = 0, n_bad = 0;
  logic [35:0] mdl [N];
  logic pw_v = 1'b0;
  logic [AW-1:0] pw_a = '0;
  logic [3:0] pw_m = 4'hF;
  logic exp_rd = 1'b0;
  logic [35:0] exp_q = '0;

  always #10 clk = ~clk;

  lw_sram #(.ADDR_W(AW)) dut (.clk(clk), .rst_n(rst_n), .sleep(sleep), .oe_n(oe_n),
    .cs_n(cs_n), .we_n(we_n), .lane_we_n(lane_we_n), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive));

  function automatic logic [35:0] pat(input int a, input int s);
    return 36'h9A5C3E172 ^ (36'(a) * 36'h00F1E2D) ^ (36'(s) * 36'h3C0471B5);
  endfunction

  task automatic chk1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s rd_drive=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chkw(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s rd_data=%h expected %h", req, act, exp);
    end
  endtask

  // One clock: drive inputs at the falling edge, model the edge, then check 5 ns after it.
  task automatic step(input logic c, input logic w, input logic [3:0] m,
                      input int a, input logic [35:0] d, input logic slp,
                      input logic oe, input string req);
    @(negedge clk);
    cs_n = c; we_n = w; lane_we_n = m; addr = AW'(a); wr_data = d;
    sleep = slp; oe_n = oe;
    if (!slp && pw_v)
      for (int l = 0; l < 4; l++)
        if (!pw_m[l]) mdl[pw_a][l*9 +: 9] = d[l*9 +: 9];
    pw_v = !slp && !c && !w;
    if (pw_v) begin pw_a = AW'(a); pw_m = m; end
    exp_rd = !slp && !c && w;
    if (exp_rd) exp_q = mdl[a];
    @(posedge clk);
    #5;
    chk1(req, rd_drive, exp_rd & ~oe & ~slp);
    chkw(req, rd_data, exp_q);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk1("R10 reset drive", rd_drive, 1'b0);
    chkw("R10 reset data", rd_data, 36'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: back-to-back full-word writes; each edge carries the previous write's data.
    for (int a = 0; a < N; a++)
      step(1'b0, 1'b0, 4'h0, a, (a == 0) ? 36'h0 : pat(a - 1, 0), 1'b0, 1'b0, "R11 write");
    step(1'b1, 1'b1, 4'h0, 0, pat(N - 1, 0), 1'b0, 1'b0, "R3 deselect");
    for (int a = 0; a < N; a++)
      step(1'b0, 1'b1, 4'hF, a, 36'hFFFFFFFFF, 1'b0, 1'b0, "R4 R1 R6 read back");
    // R8 R6 R1: every lane mask on every address, then a read of the same address on the data edge.
    for (int m = 0; m < 16; m++)
      for (int a = 0; a < N; a++) begin
        step(1'b0, 1'b0, 4'(m), a, 36'h0, 1'b0, 1'b0, "R7 write cmd");
        step(1'b0, 1'b1, 4'hF, a, pat(a, m + 1), 1'b0, 1'b0, "R8 bypass read");
        step(1'b1, 1'b0, 4'h0, (a + 1) % N, pat(a, 99), 1'b0, 1'b0, "R3 R6 deselect");
        step(1'b0, 1'b1, 4'h0, a, 36'h0, 1'b0, 1'b0, "R6 R1 lane read");
      end
    // R5: dummy read with oe_n high, then oe_n acts without a clock.
    step(1'b0, 1'b1, 4'h0, 3, 36'h0, 1'b0, 1'b1, "R5 dummy read");
    #2 oe_n = 1'b0;
    #1 chk1("R5 oe_n low drives", rd_drive, 1'b1);
    oe_n = 1'b1;
    #1 chk1("R5 oe_n high releases", rd_drive, 1'b0);
    oe_n = 1'b0;
    // R9: sleep raised mid-cycle forces drive off at once.
    #1 chk1("R5 drive back", rd_drive, 1'b1);
    sleep = 1'b1;
    #1 chk1("R9 sleep async hiz", rd_drive, 1'b0);
    sleep = 1'b0;
    // R9: sleep at the data edge drops a pending write.
    step(1'b0, 1'b0, 4'h0, 5, 36'h0, 1'b0, 1'b0, "R7 write cmd");
    step(1'b0, 1'b1, 4'h0, 5, 36'h123456789, 1'b1, 1'b0, "R9 sleep data edge");
    step(1'b0, 1'b1, 4'h0, 5, 36'h0, 1'b0, 1'b0, "R9 dropped write");
    // R2: a write command during sleep is ignored, and so is the data that follows.
    step(1'b0, 1'b0, 4'h0, 6, 36'h0, 1'b1, 1'b0, "R2 sleep cmd");
    step(1'b1, 1'b1, 4'h0, 6, 36'h0AAAAAAAA, 1'b0, 1'b0, "R2 stray data");
    step(1'b0, 1'b1, 4'h0, 6, 36'h0, 1'b0, 1'b0, "R2 read unchanged");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule